// File: doc/BRIEF.md
# Dual-Strobe Reversible Cascadable Counter

This block is a 4-bit binary counter with two separate count strobes: a rising edge on one strobe adds one to the count, and a rising edge on the other subtracts one. The count wraps modulo 16 in both directions. A clear input forces the count to zero. An active-low load input copies a 4-bit data word into the count. Clear takes priority over load, and both take priority over the strobes.

Two active-low terminal outputs idle high. The carry output follows the low phase of the up strobe while the count sits at its maximum. The borrow output follows the low phase of the down strobe while the count sits at zero. Wiring carry to the up strobe of the next stage, and borrow to its down strobe, builds wider counters without any other logic.

All control inputs are treated as asynchronous to the system clock `clk`. Each one passes through a synchronizer. Strobe edges are found by comparing the synchronized level with the level seen in the previous cycle. A strobe rise changes the count on the third `clk` rising edge after it. The terminal outputs respond two edges after a strobe changes.

Top module: `dual_strobe_counter`

## Requirements
- R1: When only the up strobe shows a synchronized rise, and clear is low and load is high, the count increments by one. The value 15 wraps to 0. The new count appears on the third `clk` edge after the strobe rises.
- R2: When only the down strobe shows a synchronized rise, and clear is low and load is high, the count decrements by one. The value 0 wraps to 15.
- R3: The count holds in two cases: when no strobe rises, and when both strobes rise in the same cycle.
- R4: Clear high forces the count to 0. This overrides load and both strobes. After the system reset `rst_n`, the count is 0 and both terminal outputs are high.
- R5: With clear low and `load_n` low, the count takes the value of `din`. Strobe edges that arrive while load is active are dropped.
- R6: `carry_n` is 0 exactly when the count is 15 and the synchronized up strobe is 0. Otherwise it is 1, so it rises together with the up strobe.
- R7: `borrow_n` is 0 exactly when the count is 0 and the synchronized down strobe is 0. Otherwise it is 1.
- R8: Suppose a strobe is low while clear or load is active and is still low after the release. Its next rise is counted.
- R9: Two instances can be chained into an 8-bit counter. The low stage's `carry_n` drives the high stage's `inc_stb`, and its `borrow_n` drives the high stage's `dec_stb`. The pair then counts modulo 256 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control input |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr | input | 1 | Active-high clear; forces the count to zero |
| load_n | input | 1 | Active-low load of `din` |
| din | input | WIDTH | Data word for load |
| inc_stb | input | 1 | Up strobe; counts on its rising edge and idles high |
| dec_stb | input | 1 | Down strobe; counts on its rising edge and idles high |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry; echoes the low phase of the up strobe at the maximum count |
| borrow_n | output | 1 | Active-low borrow; echoes the low phase of the down strobe at zero |

## Verification
A bad count register shows on `q` within three clock edges of the strobe edge that caused it. In a chained pair, the error also shows one strobe period later as a missing or extra transfer into the high stage. A stale edge-detect level shows as a count that is lost or doubled after a strobe is held low through clear or load. A fault in the terminal logic shows within two clock edges of the strobe falling, as a carry or borrow that fails to track the strobe at 15 or 0. That fault then stops the high stage from counting when the 8-bit value wraps.

// File: rtl/dsc_pkg.sv
// Shared definitions for the dual-strobe counter.
// Assumes: one update kind per clock cycle, chosen by priority.
package dsc_pkg;
    typedef enum logic [2:0] {
        STEP_HOLD  = 3'd0,
        STEP_UP    = 3'd1,
        STEP_DOWN  = 3'd2,
        STEP_LOAD  = 3'd3,
        STEP_CLEAR = 3'd4
    } step_t;
endpackage

// File: rtl/dsc_sync.sv
// Multi-flop synchronizer for a vector of unrelated asynchronous bits.
// Assumes: each bit is independent; STAGES >= 1; INIT is the idle level
// the bits take during system reset.
module dsc_sync #(
    parameter int          N      = 1,
    parameter int          STAGES = 2,
    parameter logic [N-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg [STAGES];

    // Shift the sampled inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dsc_edge.sv
// Rising-edge detector for synchronized strobes.
// Assumes: inputs are already in the clk domain. The stored level is
// updated every cycle, whether or not the edge is used downstream.
module dsc_edge #(
    parameter int           N    = 2,
    parameter logic [N-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_now,
    output logic [N-1:0] lvl_prev,
    output logic [N-1:0] rise
);
    // Remember each strobe's level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= INIT;
        else        lvl_prev <= lvl_now;
    end

    assign rise = lvl_now & ~lvl_prev;
endmodule

// File: rtl/dsc_step_decode.sv
// Picks this cycle's update kind by priority:
// clear, then load, then a single strobe edge.
// Assumes: all inputs are synchronized. When both strobes rise in the
// same cycle, the result is hold.
module dsc_step_decode
    import dsc_pkg::*;
(
    input  logic  clr_s,
    input  logic  load_s_n,
    input  logic  up_rise,
    input  logic  dn_rise,
    output step_t step
);
    // Priority selection of the update kind.
    always_comb begin
        if (clr_s)                    step = STEP_CLEAR;
        else if (!load_s_n)           step = STEP_LOAD;
        else if (up_rise && !dn_rise) step = STEP_UP;
        else if (dn_rise && !up_rise) step = STEP_DOWN;
        else                          step = STEP_HOLD;
    end
endmodule

// File: rtl/dsc_count_reg.sv
// Count register that applies one decoded update per clock cycle.
// Assumes: the load data is stable while load is active; arithmetic wraps
// modulo 2**WIDTH.
module dsc_count_reg
    import dsc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_t            step,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Register the next count selected by the update kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (step)
                STEP_CLEAR: q <= '0;
                STEP_LOAD:  q <= din;
                STEP_UP:    q <= q + ONE;
                STEP_DOWN:  q <= q - ONE;
                default:    q <= q;
            endcase
        end
    end
endmodule

// File: rtl/dual_strobe_counter.sv
// Reversible counter with separate up and down strobes, clear, load and
// cascadable active-low carry/borrow outputs.
// Assumes: strobes idle high, and only one strobe is used to count at a
// time. All controls are asynchronous to clk and are synchronized here.
module dual_strobe_counter
    import dsc_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             inc_stb,
    input  logic             dec_stb,
    output logic [WIDTH-1:0] q,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
    localparam logic [3:0]       CTL_IDLE = 4'b1110;

    logic [3:0] ctl_s;
    logic       clr_s, load_s_n, inc_s, dec_s;
    logic [1:0] lvl_prev, rise;
    logic       inc_l, dec_l;
    step_t      step;

    dsc_sync #(.N(4), .STAGES(SYNC_STAGES), .INIT(CTL_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dec_stb, inc_stb, load_n, clr}),
        .q     (ctl_s)
    );

    assign clr_s    = ctl_s[0];
    assign load_s_n = ctl_s[1];
    assign inc_s    = ctl_s[2];
    assign dec_s    = ctl_s[3];

    dsc_edge #(.N(2), .INIT(2'b11)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_now  ({dec_s, inc_s}),
        .lvl_prev (lvl_prev),
        .rise     (rise)
    );

    assign inc_l = lvl_prev[0];
    assign dec_l = lvl_prev[1];

    dsc_step_decode u_dec (
        .clr_s    (clr_s),
        .load_s_n (load_s_n),
        .up_rise  (rise[0]),
        .dn_rise  (rise[1]),
        .step     (step)
    );

    dsc_count_reg #(.WIDTH(WIDTH)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .din   (din),
        .q     (q)
    );

    // Terminal outputs echo the low phase of the matching strobe at the count limits.
    assign carry_n  = ~((q == TOP_VAL) & ~inc_s);
    assign borrow_n = ~((q == '0) & ~dec_s);
endmodule

// File: rtl/dsc_checker.sv
// Assertion checker for dual_strobe_counter, attached with bind below.
// Assumes: it observes the synchronized controls and the edge-detect levels.
module dsc_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_s,
    input logic             load_s_n,
    input logic             inc_s,
    input logic             dec_s,
    input logic             inc_l,
    input logic             dec_l,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             carry_n,
    input logic             borrow_n
);
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && load_s_n && inc_s && !inc_l && !(dec_s && !dec_l)) |=> (q == $past(q) + ONE)); // R1
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && load_s_n && dec_s && !dec_l && !(inc_s && !inc_l)) |=> (q == $past(q) - ONE)); // R2
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && load_s_n && !(inc_s && !inc_l) && !(dec_s && !dec_l)) |=> $stable(q)); // R3
    AST_HOLD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && load_s_n && inc_s && !inc_l && dec_s && !dec_l) |=> $stable(q)); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> (q == '0)); // R4
    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && !load_s_n) |=> (q == $past(din))); // R5
    AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (q == TOP_VAL)); // R6
    AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (q == '0)); // R7
endmodule

bind dual_strobe_counter dsc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_s    (clr_s),
    .load_s_n (load_s_n),
    .inc_s    (inc_s),
    .dec_s    (dec_s),
    .inc_l    (inc_l),
    .dec_l    (dec_l),
    .din      (din),
    .q        (q),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
);

// File: tb/sim_dual_strobe_counter.sv
module sim_dual_strobe_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic       up = 1'b1;
    logic       dn = 1'b1;
    logic [3:0] q_lo, q_hi;
    logic       cy_lo, bw_lo, cy_hi, bw_hi;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    int         model = 0;

    always #2 clk = ~clk;

    dual_strobe_counter u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din[3:0]),
        .inc_stb(up), .dec_stb(dn), .q(q_lo), .carry_n(cy_lo), .borrow_n(bw_lo)
    );

    dual_strobe_counter u1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din[7:4]),
        .inc_stb(cy_lo), .dec_stb(bw_lo), .q(q_hi), .carry_n(cy_hi), .borrow_n(bw_hi)
    );

    task automatic settle();
        repeat (12) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One up pulse on the low stage, with carry checks during the low phase.
    task automatic pulse_up();
        up = 1'b0;
        settle();
        chk("R6 low-stage carry", int'(cy_lo), ((model & 15) == 15) ? 0 : 1);
        chk("R9 chained carry", int'(cy_hi), (model == 255) ? 0 : 1);
        up = 1'b1;
        settle();
        model = (model + 1) % 256;
        chk("R1/R9 up count", int'({q_hi, q_lo}), model);
        chk("R6 carry released", int'(cy_lo), 1);
    endtask

    // One down pulse on the low stage, with borrow checks during the low phase.
    task automatic pulse_dn();
        dn = 1'b0;
        settle();
        chk("R7 low-stage borrow", int'(bw_lo), ((model & 15) == 0) ? 0 : 1);
        chk("R9 chained borrow", int'(bw_hi), (model == 0) ? 0 : 1);
        dn = 1'b1;
        settle();
        model = (model + 255) % 256;
        chk("R2/R9 down count", int'({q_hi, q_lo}), model);
        chk("R7 borrow released", int'(bw_lo), 1);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R4 reset count", int'({q_hi, q_lo}), 0);
        chk("R4 reset carry", int'(cy_hi), 1);
        chk("R4 reset borrow", int'(bw_hi), 1);

        // R1/R6/R9: full up sweep with an 8-bit wrap at 255.
        for (int i = 0; i < 300; i++) pulse_up();
        // R2/R7/R9: full down sweep with an 8-bit wrap at 0.
        for (int i = 0; i < 300; i++) pulse_dn();

        // R5: load, with an up pulse dropped while load is active.
        din = 8'hA5; load_n = 1'b0;
        settle();
        chk("R5 load value", int'({q_hi, q_lo}), 8'hA5);
        up = 1'b0; settle(); up = 1'b1; settle();
        chk("R5 edge dropped in load", int'({q_hi, q_lo}), 8'hA5);
        load_n = 1'b1;
        settle();
        chk("R5 value kept after load", int'({q_hi, q_lo}), 8'hA5);

        // R4: clear overrides an active load.
        din = 8'h3C; load_n = 1'b0; clr = 1'b1;
        settle();
        chk("R4 clear beats load", int'({q_hi, q_lo}), 0);
        clr = 1'b0;
        settle();
        chk("R5 load after clear", int'({q_hi, q_lo}), 8'h3C);
        load_n = 1'b1;
        settle();

        // R8: up strobe held low through a clear, then its rise counts.
        up = 1'b0;
        settle();
        clr = 1'b1; settle(); clr = 1'b0; settle();
        chk("R8 cleared while strobe low", int'({q_hi, q_lo}), 0);
        up = 1'b1;
        settle();
        chk("R8 count after clear", int'({q_hi, q_lo}), 1);

        // R8: down strobe held low through a load; the borrow into the high stage is held low too.
        dn = 1'b0;
        settle();
        din = 8'h50; load_n = 1'b0; settle(); load_n = 1'b1; settle();
        chk("R8 loaded while strobe low", int'({q_hi, q_lo}), 8'h50);
        dn = 1'b1;
        settle();
        chk("R8 count after load", int'({q_hi, q_lo}), 8'h4F);

        // R3: idle strobes keep the count.
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk("R3 idle hold", int'({q_hi, q_lo}), 8'h4F);

        // R3: simultaneous rises cancel.
        din = 8'h37; load_n = 1'b0; settle(); load_n = 1'b1; settle();
        up = 1'b0; dn = 1'b0;
        settle();
        up = 1'b1; dn = 1'b1;
        settle();
        chk("R3 both edges hold", int'({q_hi, q_lo}), 8'h37);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule